// File: doc/BRIEF.md
# Intra 4x4 DC Predictor

This block forms the flat (DC) prediction for a 4x4 luma block in a video encoder or decoder. The caller presents the four samples of the column to the left of the block, the four samples of the row above it, and one flag per edge that says whether that edge may be used. A one-cycle start pulse makes the block take the mean of the usable edges, with rounding, and write that one value into all sixteen positions of the prediction block.

The number of samples averaged follows the flags. With both edges usable, all eight samples are averaged. With one edge usable, only its four samples are averaged. With neither usable, the result is mid-grey. Samples on an edge whose flag is low have no influence on the result. The prediction appears on a registered output one clock after start and stays there until the next start.

Top module: `intra_dc4_pred`

## Requirements
- R1: When start is sampled high with left_ok=1 and up_ok=1, every output sample becomes (L0+L1+L2+L3+U0+U1+U2+U3+4)>>3.
- R2: When start is sampled high with left_ok=1 and up_ok=0, every output sample becomes (L0+L1+L2+L3+2)>>2.
- R3: When start is sampled high with left_ok=0 and up_ok=1, every output sample becomes (U0+U1+U2+U3+2)>>2.
- R4: When start is sampled high with left_ok=0 and up_ok=0, every output sample becomes 128 (0x80).
- R5: Samples of an edge whose flag is low have no effect on the output.
- R6: All sixteen output samples carry the same value; sample at row r, column c sits at pred_blk bits [8*(4r+c)+7 : 8*(4r+c)]. Left sample Lk sits at left_px bits [8k+7:8k], above sample Uk at up_px bits [8k+7:8k].
- R7: pred_valid is high in the cycle after each clock edge at which start is sampled high, and low otherwise.
- R8: pred_blk keeps its value in cycles that follow an edge where start was low.
- R9: A synchronous active-high reset clears pred_valid and pred_blk to zero.
- R10: Sums of full-scale samples do not overflow: all samples at 255 give 255 in every mode that uses them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Take inputs and compute one prediction |
| left_ok | input | 1 | Left column may be used |
| up_ok | input | 1 | Row above may be used |
| left_px | input | 32 | Left samples L0..L3, L0 in the low byte |
| up_px | input | 32 | Above samples U0..U3, U0 in the low byte |
| pred_valid | output | 1 | Prediction updated in this cycle |
| pred_blk | output | 128 | Sixteen predicted samples, row-major, row 0 column 0 in the low byte |

## Verification
Each flag combination is applied with sample sets whose sums fall just below and just at a rounding step, so a wrong rounding constant or shift amount shows up as an off-by-one. Unusable edges are loaded with full-scale or odd-looking data, which separates correct masking from a sum that leaks the other edge. Full-scale inputs in the eight-sample and four-sample modes expose a truncated accumulator, and back-to-back starts, idle cycles with changing inputs and a mid-run reset separate the strobe, hold and clear behaviour.

// File: rtl/intra_dc4_pkg.sv
package intra_dc4_pkg;

    // Which neighbour edges take part in the mean; bit 1 = left, bit 0 = above.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_UP   = 2'b01,
        EDGE_LEFT = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic left;
        logic up;
    } nbr_avail_t;

    function automatic edge_sel_e pick_edges(nbr_avail_t a);
        return edge_sel_e'({a.left, a.up});
    endfunction

endpackage

// File: rtl/dc4_edge_sum.sv
module dc4_edge_sum #(
    parameter int N     = 4,
    parameter int PIX_W = 8,
    localparam int SUM_W = PIX_W + $clog2(N)
) (
    input  logic [N*PIX_W-1:0] px,
    input  logic               en,
    output logic [SUM_W-1:0]   sum
);
    logic [SUM_W-1:0] part [N+1];

    assign part[0] = '0;
    for (genvar g = 0; g < N; g++) begin : g_acc
        assign part[g+1] = part[g] + SUM_W'(px[g*PIX_W +: PIX_W]);
    end

    // An unusable edge contributes nothing.
    assign sum = en ? part[N] : '0;
endmodule

// File: rtl/dc4_mean.sv
module dc4_mean
    import intra_dc4_pkg::*;
#(
    parameter int N     = 4,
    parameter int PIX_W = 8,
    localparam int EW    = PIX_W + $clog2(N),
    localparam int TOT_W = EW + 2,
    localparam int SH1   = $clog2(N),
    localparam int SH2   = SH1 + 1
) (
    input  logic [EW-1:0]    sum_l,
    input  logic [EW-1:0]    sum_u,
    input  edge_sel_e        sel,
    output logic [PIX_W-1:0] mean
);
    logic [TOT_W-1:0] tot;
    logic [TOT_W-1:0] rnd;

    assign tot = TOT_W'(sum_l) + TOT_W'(sum_u);

    always_comb begin
        unique case (sel)
            EDGE_BOTH: rnd = (tot + (TOT_W'(1) << (SH2 - 1))) >> SH2;
            EDGE_LEFT,
            EDGE_UP:   rnd = (tot + (TOT_W'(1) << (SH1 - 1))) >> SH1;
            default:   rnd = TOT_W'(1) << (PIX_W - 1);
        endcase
    end

    assign mean = rnd[PIX_W-1:0];
endmodule

// File: rtl/dc4_fill.sv
module dc4_fill #(
    parameter int N     = 4,
    parameter int PIX_W = 8,
    localparam int BLK_W = N * N * PIX_W
) (
    input  logic [PIX_W-1:0] mean,
    output logic [BLK_W-1:0] blk
);
    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            assign blk[(r*N + c)*PIX_W +: PIX_W] = mean;
        end
    end
endmodule

// File: rtl/intra_dc4_pred.sv
module intra_dc4_pred
    import intra_dc4_pkg::*;
#(
    parameter int N     = 4,
    parameter int PIX_W = 8,
    localparam int EW    = PIX_W + $clog2(N),
    localparam int BLK_W = N * N * PIX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               left_ok,
    input  logic               up_ok,
    input  logic [N*PIX_W-1:0] left_px,
    input  logic [N*PIX_W-1:0] up_px,
    output logic               pred_valid,
    output logic [BLK_W-1:0]   pred_blk
);
    nbr_avail_t       avail;
    edge_sel_e        sel;
    logic [EW-1:0]    sum_l;
    logic [EW-1:0]    sum_u;
    logic [PIX_W-1:0] mean;
    logic [BLK_W-1:0] blk_d;

    assign avail = '{left: left_ok, up: up_ok};
    assign sel   = pick_edges(avail);

    dc4_edge_sum #(.N(N), .PIX_W(PIX_W)) u_sum_left (
        .px (left_px),
        .en (avail.left),
        .sum(sum_l)
    );

    dc4_edge_sum #(.N(N), .PIX_W(PIX_W)) u_sum_up (
        .px (up_px),
        .en (avail.up),
        .sum(sum_u)
    );

    dc4_mean #(.N(N), .PIX_W(PIX_W)) u_mean (
        .sum_l(sum_l),
        .sum_u(sum_u),
        .sel  (sel),
        .mean (mean)
    );

    dc4_fill #(.N(N), .PIX_W(PIX_W)) u_fill (
        .mean(mean),
        .blk (blk_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_valid <= 1'b0;
            pred_blk   <= '0;
        end else begin
            pred_valid <= start;
            if (start) begin
                pred_blk <= blk_d;
            end
        end
    end
endmodule

// File: rtl/intra_dc4_chk.sv
module intra_dc4_chk #(
    parameter int N     = 4,
    parameter int PIX_W = 8,
    localparam int BLK_W = N * N * PIX_W
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             left_ok,
    input logic             up_ok,
    input logic             pred_valid,
    input logic [BLK_W-1:0] pred_blk
);
    logic lanes_equal;

    always_comb begin
        lanes_equal = 1'b1;
        for (int i = 1; i < N * N; i++) begin
            if (pred_blk[i*PIX_W +: PIX_W] != pred_blk[PIX_W-1:0]) lanes_equal = 1'b0;
        end
    end

    AST_VALID_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
        start |=> pred_valid);                                              // R7
    AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> $past(start));                                       // R7
    AST_LANES_EQUAL: assert property (@(posedge clk) disable iff (rst)
        lanes_equal);                                                       // R6
    AST_NO_EDGE_GREY: assert property (@(posedge clk) disable iff (rst)
        (start && !left_ok && !up_ok) |=> (pred_blk[PIX_W-1:0] == PIX_W'(1) << (PIX_W - 1))); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(pred_blk));                                      // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!pred_valid && pred_blk == '0));                           // R9
endmodule

bind intra_dc4_pred intra_dc4_chk #(.N(N), .PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .left_ok   (left_ok),
    .up_ok     (up_ok),
    .pred_valid(pred_valid),
    .pred_blk  (pred_blk)
);

// File: tb/intra_dc4_pred_tb.sv
module intra_dc4_pred_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         left_ok = 1'b0;
    logic         up_ok = 1'b0;
    logic [31:0]  left_px = '0;
    logic [31:0]  up_px = '0;
    logic         pred_valid;
    logic [127:0] pred_blk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    intra_dc4_pred u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .left_ok   (left_ok),
        .up_ok     (up_ok),
        .left_px   (left_px),
        .up_px     (up_px),
        .pred_valid(pred_valid),
        .pred_blk  (pred_blk)
    );

    // {req[3:0], left_ok, up_ok, left_px[31:0], up_px[31:0], expected[7:0]}
    localparam int NV = 10;
    localparam logic [77:0] VEC [NV] = '{
        {4'd1,  2'b11, 32'h281E140A, 32'h04030201, 8'h0E}, // R1 sums 100+10
        {4'd1,  2'b11, 32'h03000000, 32'h00000000, 8'h00}, // R1 7>>3 rounds down
        {4'd1,  2'b11, 32'h04000000, 32'h00000000, 8'h01}, // R1 8>>3 rounds up
        {4'd10, 2'b11, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'hFF}, // R10 eight full-scale
        {4'd2,  2'b10, 32'h04030201, 32'hFFFFFFFF, 8'h03}, // R2 above ignored
        {4'd2,  2'b10, 32'h00010101, 32'h80808080, 8'h01}, // R2 sum 3 rounds up
        {4'd3,  2'b01, 32'hFFFFFFFF, 32'h67666564, 8'h66}, // R3 left ignored
        {4'd10, 2'b01, 32'h00000000, 32'hFFFFFFFF, 8'hFF}, // R10 four full-scale
        {4'd4,  2'b00, 32'h12345678, 32'h9ABCDEF0, 8'h80}, // R4 mid-grey
        {4'd3,  2'b01, 32'hFFFFFFFF, 32'h01000000, 8'h00}  // R3 sum 1 rounds down
    };

    task automatic check_bit(input logic act, input logic exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // R6: every lane must equal the expected mean.
    task automatic check_blk(input logic [7:0] exp, input string req, input string what);
        int wrong = 0;
        logic [7:0] first_bad = '0;
        for (int i = 0; i < 16; i++) begin
            if (pred_blk[i*8 +: 8] !== exp) begin
                if (wrong == 0) first_bad = pred_blk[i*8 +: 8];
                wrong++;
            end
        end
        total++;
        if (wrong != 0) begin
            bad++;
            $display("FAIL %s %s: actual=%0d (in %0d lanes) expected=%0d", req, what, first_bad, wrong, exp);
        end
    endtask

    // Drives one start pulse; returns at the negedge where the result is visible.
    task automatic fire(input logic lok, input logic uok, input logic [31:0] l, input logic [31:0] u);
        @(negedge clk);
        left_ok = lok; up_ok = uok; left_px = l; up_px = u; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 state during and after reset
        check_bit(pred_valid, 1'b0, "R9", "valid in reset");
        check_blk(8'h00, "R9", "block in reset");
        rst = 1'b0;
        @(negedge clk);
        check_bit(pred_valid, 1'b0, "R7", "valid idle before start");

        for (int v = 0; v < NV; v++) begin
            fire(VEC[v][73], VEC[v][72], VEC[v][71:40], VEC[v][39:8]);
            check_bit(pred_valid, 1'b1, "R7", "valid after start");
            check_blk(VEC[v][7:0], $sformatf("R%0d", VEC[v][77:74]), $sformatf("vector %0d", v));
            @(negedge clk);
            check_bit(pred_valid, 1'b0, "R7", "valid drops after one cycle");
        end

        // R5: left-only result independent of above samples
        fire(1'b1, 1'b0, 32'h10203040, 32'h00000000);
        check_blk(8'h28, "R5", "left-only, above zero");
        fire(1'b1, 1'b0, 32'h10203040, 32'hFFEEDDCC);
        check_blk(8'h28, "R5", "left-only, above changed");
        // R5: up-only result independent of left samples
        fire(1'b0, 1'b1, 32'hA5A5A5A5, 32'h08080808);
        check_blk(8'h08, "R5", "up-only, left noise");

        // R8: inputs change without start; output holds
        @(negedge clk);
        left_ok = 1'b1; up_ok = 1'b1; left_px = 32'hFFFFFFFF; up_px = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        check_blk(8'h08, "R8", "hold while idle");
        check_bit(pred_valid, 1'b0, "R8", "valid low while idle");

        // R7: back-to-back starts keep valid high and take the newer value
        @(negedge clk);
        left_ok = 1'b1; up_ok = 1'b0; left_px = 32'h0A0A0A0A; start = 1'b1;
        @(negedge clk);
        check_bit(pred_valid, 1'b1, "R7", "first of back-to-back");
        check_blk(8'h0A, "R2", "first of back-to-back");
        left_ok = 1'b0; up_ok = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check_bit(pred_valid, 1'b1, "R7", "second of back-to-back");
        check_blk(8'h80, "R4", "second of back-to-back");

        // R9: reset in mid-run clears the held block
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_bit(pred_valid, 1'b0, "R9", "valid after mid reset");
        check_blk(8'h00, "R9", "block after mid reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule